// File: doc/BRIEF.md
# Countdown Timer with Register Interface

This block is a single-channel down-counting timer that a processor reaches through a small word-wide register interface. Software loads a reload value, sets a run bit and a reload/interrupt bit in the control word, and then watches a read-only live count or waits for the interrupt line. The count only moves on clock edges where the `tick` input is high, so a prescaler outside the block can pick any tick rate below the bus clock.

The block holds four 32-bit words: a free scratch/status word, a control word, a reload (period) word and the live count. When running, a nonzero count steps down by one per tick. A count of zero is reloaded from the period word on a tick only when the reload/interrupt bit is set, and otherwise it stays at zero. Each accepted request gets exactly one response a cycle later. An illegal access is reported through an error flag on that response and leaves every word untouched.

Top module: `cdtimer`

## Requirements
- R1: After reset the status, control, period and count words all read as zero, `irq` is low and `rsp_valid` is low.
- R2: Word offsets: 0x0 status, 0x4 control, 0x8 period, 0xC live count. A legal write to status, control or period stores the full word, and a later read of that offset returns it. A legal read returns the word's value as it stood in the cycle the request was accepted.
- R3: The count word is read-only. A write to offset 0xC is illegal, raises `rsp_err` and changes no word.
- R4: An access is legal only when `req_size` is 2 (32-bit word; 0 is byte, 1 is halfword, 3 is reserved), `req_addr[1:0]` is zero and the address is below 0x10. Any other access raises `rsp_err`, returns zero read data and changes no word.
- R5: Control bit 2 is the run bit. The count changes only on an edge where `tick` is high and the run bit is set. With either one low the count holds.
- R6: On a counting edge a nonzero count drops by one. A zero count loads the period word if control bit 0 is set, and stays zero if it is clear.
- R7: `irq` is a registered level that is high exactly when the count is zero and control bit 0 is set, whatever the run bit. It changes on the same edge as the count or control word that causes it.
- R8: A counting edge uses the control and period values held before that edge. A control write that sets the run bit therefore starts counting from the next tick, not the tick that lands on the write edge.
- R9: `req_ready` is always high. Every accepted request produces exactly one `rsp_valid` pulse on the following cycle, and no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for this edge |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code, 2 = word |
| req_wdata | input | W | Write data |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_err | output | 1 | Illegal access flag, valid with rsp_valid |
| rsp_rdata | output | W | Read data, valid with rsp_valid |
| irq | output | 1 | Count is zero and reload/interrupt bit set |

## Verification
Every result is due one edge after its cause. A request and a tick offered before an edge produce the response, the new count and the new `irq` level right after that edge. The bench drives each step just after a falling edge, lets one rising edge pass and samples on the next falling edge. It compares against a bench model that is advanced by exactly that one edge. Read data is compared with the model state from before the edge, while `irq` and later count reads are compared with the state after it. This one-edge rule covers the control-write-with-tick case in R8.

// File: rtl/cdtimer.sv
module cdtimer #(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [W-1:0]      req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [W-1:0]      rsp_rdata,
  output logic              irq
);
  localparam logic [1:0] SIZE_WORD = 2'd2;
  localparam logic [1:0] IDX_STAT  = 2'd0;
  localparam logic [1:0] IDX_CTRL  = 2'd1;
  localparam logic [1:0] IDX_PER   = 2'd2;
  localparam logic [1:0] IDX_CNT   = 2'd3;
  localparam int BIT_RELOAD = 0;
  localparam int BIT_RUN    = 2;

  logic [W-1:0] stat_q, ctrl_q, per_q, cnt_q;
  logic [W-1:0] ctrl_d, cnt_d, rd_mux;

  wire [1:0] idx      = req_addr[3:2];
  wire       in_range = ((req_addr >> 4) == '0) && (req_addr[1:0] == 2'b00);
  wire       legal    = in_range && (req_size == SIZE_WORD) && !(req_write && idx == IDX_CNT);
  wire       wr_ok    = req_valid && req_write && legal;
  wire       counting = tick && ctrl_q[BIT_RUN];

  assign req_ready = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (counting) begin
      if (cnt_q != '0)             cnt_d = cnt_q - 1'b1;
      else if (ctrl_q[BIT_RELOAD]) cnt_d = per_q;
    end
  end

  assign ctrl_d = (wr_ok && idx == IDX_CTRL) ? req_wdata : ctrl_q;

  always_comb begin
    case (idx)
      IDX_STAT: rd_mux = stat_q;
      IDX_CTRL: rd_mux = ctrl_q;
      IDX_PER:  rd_mux = per_q;
      default:  rd_mux = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q    <= '0;
      ctrl_q    <= '0;
      per_q     <= '0;
      cnt_q     <= '0;
      irq       <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_ok && idx == IDX_STAT) stat_q <= req_wdata;
      if (wr_ok && idx == IDX_PER)  per_q  <= req_wdata;
      ctrl_q    <= ctrl_d;
      cnt_q     <= cnt_d;
      irq       <= (cnt_d == '0) && ctrl_d[BIT_RELOAD];
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !legal;
      rsp_rdata <= (req_valid && legal && !req_write) ? rd_mux : '0;
    end
  end

  a_r9_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r4_err_in_response: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r4_illegal_keeps_words: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !legal) |=> ($stable(stat_q) && $stable(ctrl_q) && $stable(per_q)));
  a_r3_count_write_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == SIZE_WORD && req_addr == ADDR_W'(12)) |=> rsp_err);
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && ctrl_q[BIT_RUN]) |=> $stable(cnt_q));
  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl_q[BIT_RUN] && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !ctrl_q[BIT_RELOAD]) |=> cnt_q == '0);
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (cnt_q == '0 && ctrl_q[BIT_RELOAD]));
endmodule

// File: tb/cdtimer_test.sv
`timescale 1ns/1ps
module cdtimer_test;
  localparam int W = 32;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_size = 2'd2;
  logic [W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, irq;
  logic [W-1:0] rsp_rdata;

  int total = 0, fails = 0;
  logic [W-1:0] m_stat, m_ctrl, m_per, m_cnt;

  always #2.5 clk = ~clk;

  cdtimer #(.W(W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mreg(input logic [1:0] i);
    case (i)
      2'd0: return m_stat;
      2'd1: return m_ctrl;
      2'd2: return m_per;
      default: return m_cnt;
    endcase
  endfunction

  // one bus/tick step: drive after a falling edge, sample at the next falling edge
  task automatic step(input bit tk, input bit v, input bit wr, input logic [ADDR_W-1:0] a,
                      input logic [1:0] sz, input logic [W-1:0] wd, input string tag);
    bit legal;
    logic [W-1:0] exp_rd, n_cnt, n_ctrl;
    tick = tk; req_valid = v; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    legal = (sz == 2'd2) && (a[1:0] == 2'b00) && (a < 16) && !(wr && a == 12);
    exp_rd = (v && legal && !wr) ? mreg(a[3:2]) : '0;
    n_cnt = m_cnt;
    if (tk && m_ctrl[2]) begin
      if (m_cnt != 0) n_cnt = m_cnt - 1;
      else if (m_ctrl[0]) n_cnt = m_per;
    end
    n_ctrl = m_ctrl;
    if (v && wr && legal) begin
      case (a[3:2])
        2'd0: m_stat = wd;
        2'd1: n_ctrl = wd;
        default: m_per = wd;
      endcase
    end
    m_ctrl = n_ctrl;
    m_cnt = n_cnt;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == v && req_ready, "R9 response pulse", {31'd0, rsp_valid}, {31'd0, v});
    if (v) begin
      chk(rsp_err == !legal, tag, {31'd0, rsp_err}, {31'd0, !legal});
      chk(rsp_rdata == exp_rd, tag, rsp_rdata, exp_rd);
    end
    chk(irq == (m_cnt == 0 && m_ctrl[0]), "R7 irq level", {31'd0, irq}, {31'd0, (m_cnt == 0 && m_ctrl[0])});
    req_valid = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input bit tk, input logic [ADDR_W-1:0] a, input string tag);
    step(tk, 1'b1, 1'b0, a, 2'd2, '0, tag);
  endtask
  task automatic wr(input bit tk, input logic [ADDR_W-1:0] a, input logic [W-1:0] d, input string tag);
    step(tk, 1'b1, 1'b1, a, 2'd2, d, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    m_stat = '0; m_ctrl = '0; m_per = '0; m_cnt = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!irq && !rsp_valid, "R1 reset outputs", {30'd0, irq, rsp_valid}, '0);
    for (int i = 0; i < 4; i++) rd(1'b1, ADDR_W'(4 * i), "R1 reset word");

    // R2 read back, R7 irq with run clear
    wr(1'b0, 8'h00, 32'hA5A5_0F0F, "R2 status write");
    wr(1'b0, 8'h08, 32'h0000_0003, "R2 period write");
    wr(1'b0, 8'h04, 32'h0000_0001, "R7 reload bit without run");
    rd(1'b0, 8'h00, "R2 status read");
    rd(1'b0, 8'h04, "R2 control read");
    rd(1'b0, 8'h08, "R2 period read");

    // R8 control write with a tick on the same edge
    wr(1'b1, 8'h04, 32'h0000_0005, "R8 start write");
    rd(1'b0, 8'h0C, "R8 count unchanged by write-edge tick");
    rd(1'b1, 8'h0C, "R8 first counting tick");
    rd(1'b0, 8'h0C, "R8 reload seen");

    // R5/R6 sweep over periods and reload setting
    for (int p = 0; p < 6; p++) begin
      wr(1'b0, 8'h04, 32'h0, "R5 stop");
      wr(1'b0, 8'h08, W'(p), "R2 period");
      wr(1'b0, 8'h04, 32'h5, "R6 run with reload");
      for (int i = 0; i < 14; i++) rd((i % 3) != 2, 8'h0C, "R6 reload count");
      wr(1'b1, 8'h04, 32'h4, "R6 run without reload");
      for (int i = 0; i < 10; i++) rd(1'b1, 8'h0C, "R6 hold at zero");
      wr(1'b0, 8'h04, 32'h5, "R6 reload again");
      rd(1'b1, 8'h0C, "R6 reload tick");
      rd(1'b1, 8'h0C, "R6 step");
      wr(1'b0, 8'h04, 32'h1, "R5 run cleared");
      for (int i = 0; i < 4; i++) rd(1'b1, 8'h0C, "R5 frozen with ticks");
      wr(1'b0, 8'h04, 32'h5, "R5 run set");
      for (int i = 0; i < 4; i++) rd(1'b0, 8'h0C, "R5 frozen without ticks");
    end

    // R3/R4 address, size and direction sweep
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++)
          step(a[0], 1'b1, w[0], ADDR_W'(a), 2'(s), W'(a * 32'h0101_0101) ^ W'(s),
               (w == 1 && a == 12) ? "R3 count write" : "R4 access legality");
    for (int i = 0; i < 4; i++) rd(1'b0, ADDR_W'(4 * i), "R4 words after sweep");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule